// File: doc/BRIEF.md
# Teletext Serial Bit Sampler

This block recovers a teletext serial stream that arrives on one data pin with no companion bit clock. It runs from the 27 MHz system clock, and the stream runs at 6.9375 Mbit/s. These two rates relate exactly: 144 system clocks carry 37 teletext bits. The block therefore does not use a uniform divider. It follows a repeating 37-bit schedule in which four bits last three clocks and the other thirty-three last four clocks. From that schedule it picks one system clock per bit on which to capture the pin.

A one-cycle line-start pulse arms the sequencer. From then on, the block gives a single-cycle strobe for each captured bit, the captured value, and a line-wide bit number. After the last bit of the line it raises a completion pulse and stays quiet until the next line start. Every line uses the same schedule. A built-in monitor counts the clocks in each completed 37-bit group and raises an error flag if a group does not take exactly 144 clocks.

Top module: `ttx_bit_sampler`

## Requirements
- R1: While reset is held, and after reset until the first line-start pulse, `bit_valid`, `line_done` and `cadence_err` are 0 and no strobe appears, whatever `ser_data` does.
- R2: Bits are numbered from 0 within a line. The position of bit n inside its group is p = n mod 37. The bit lasts 3 clocks when p is 9, 18, 27 or 36, and 4 clocks otherwise, so each full group of 37 bits spans 144 clocks.
- R3: Bit 0 starts in the first clock after the edge that captures `line_start`. Each later bit starts in the clock after the previous bit ends.
- R4: The captured value is `ser_data` in clock 2 of a 4-clock bit, or in clock 1 of a 3-clock bit, counting the bit's clocks from 0. The strobe `bit_valid` is high for exactly the one clock that follows the capture clock.
- R5: `bit_index` carries the line-wide number of the bit being strobed. It counts 0, 1, 2, … through 359 with one step per strobe and does not restart at group boundaries.
- R6: `line_done` is high for one clock, together with the strobe for bit 359. After that no strobe appears until the next line-start pulse.
- R7: A line-start pulse in the middle of a line restarts the line at bit 0. In the clock after the capturing edge there is no strobe and no `line_done`, even if a capture of the old line was due on that edge.
- R8: `cadence_err` goes high if a completed 37-bit group does not take exactly 144 clocks. It stays 0 under the correct schedule and is cleared by a line start.
- R9: Two strobes are never in adjacent clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle pulse that starts a new line |
| ser_data | input | 1 | Serial teletext data pin |
| bit_valid | output | 1 | One-cycle strobe for each captured bit |
| bit_data | output | 1 | Captured bit value, valid with the strobe |
| bit_index | output | 9 | Line-wide number of the strobed bit |
| line_done | output | 1 | One-cycle pulse with the final bit of a line |
| cadence_err | output | 1 | Set when a completed group does not take 144 clocks |

## Verification
The bench builds the block with its default parameters: 37-bit groups, short bits every ninth position starting at position 9, 4- and 3-clock bit lengths, and 360 bits per line. With these values one full line covers nine complete groups and then stops 27 bits into the tenth. This exercises every group wrap, the reload of the short-bit spacing, and a line end that falls in a partial group.

The data pin is driven with the true bit value only in the expected capture clock and with the inverted value in the other clocks of that bit. As a result, any capture on the wrong clock shows up as a wrong `bit_data`.

Restarts are placed at random points in a line, and one restart is placed exactly on a capture edge.

// File: rtl/ttx_pkg.sv
// Package ttx_pkg
// Shared types for the teletext bit sampler.
package ttx_pkg;

    // Sequencer state: waiting for a line, or sampling one.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/ttx_cadence.sv
// Module ttx_cadence
// Tracks the position of the current bit inside its group and says whether
// that bit is a short one.
// Assumes: FIRST_SHORT < GROUP_BITS and SHORT_EVERY >= 1. `advance` pulses on
// the last clock of each bit.
module ttx_cadence #(
    parameter int GROUP_BITS  = 37,
    parameter int FIRST_SHORT = 9,
    parameter int SHORT_EVERY = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic is_short,
    output logic group_last
);
    localparam int PW = $clog2(GROUP_BITS);
    localparam int SW = $clog2(FIRST_SHORT + SHORT_EVERY + 1);
    localparam logic [PW-1:0] POS_LAST  = PW'(GROUP_BITS - 1);
    localparam logic [SW-1:0] SKIP_INIT = SW'(FIRST_SHORT);
    localparam logic [SW-1:0] SKIP_RELD = SW'(SHORT_EVERY - 1);

    logic [PW-1:0] pos;
    logic [SW-1:0] skip;

    assign is_short   = (skip == '0);
    assign group_last = (pos == POS_LAST);

    // Step the group position and the distance to the next short bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos  <= '0;
            skip <= SKIP_INIT;
        end else if (advance) begin
            if (group_last) begin
                pos  <= '0;
                skip <= SKIP_INIT;
            end else begin
                pos  <= pos + 1'b1;
                skip <= is_short ? SKIP_RELD : skip - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ttx_bit_timer.sv
// Module ttx_bit_timer
// Counts the system clocks inside one bit. It flags the mid-bit capture
// clock and the last clock of the bit.
// Assumes: SHORT_CLKS <= LONG_CLKS. The capture clock is len/2, counted from 0.
module ttx_bit_timer #(
    parameter int LONG_CLKS  = 4,
    parameter int SHORT_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic is_short,
    output logic sample_now,
    output logic bit_end
);
    localparam int CW = $clog2(LONG_CLKS + 1);
    localparam logic [CW-1:0] L_MID  = CW'(LONG_CLKS / 2);
    localparam logic [CW-1:0] S_MID  = CW'(SHORT_CLKS / 2);
    localparam logic [CW-1:0] L_LAST = CW'(LONG_CLKS - 1);
    localparam logic [CW-1:0] S_LAST = CW'(SHORT_CLKS - 1);

    logic [CW-1:0] cnt;

    assign sample_now = run && (cnt == (is_short ? S_MID : L_MID));
    assign bit_end    = run && (cnt == (is_short ? S_LAST : L_LAST));

    // Advance the in-bit clock count, wrapping at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ttx_group_monitor.sv
// Module ttx_group_monitor
// Counts the clocks spent in each group and sets a sticky error if a group
// does not end on exactly GROUP_CLKS clocks.
// Assumes: `group_end` pulses on the last clock of the last bit of a group.
module ttx_group_monitor #(
    parameter int GROUP_CLKS = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic group_end,
    output logic err
);
    localparam int NW = $clog2(GROUP_CLKS + 1);
    localparam logic [NW-1:0] N_LAST = NW'(GROUP_CLKS - 1);

    logic [NW-1:0] cnt;

    // Count group clocks and flag early or late group ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            err <= 1'b0;
        end else if (run) begin
            if (group_end) begin
                if (cnt != N_LAST) err <= 1'b1;
                cnt <= '0;
            end else if (cnt == N_LAST) begin
                err <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ttx_bit_sampler.sv
// Module ttx_bit_sampler (top)
// Recovers a teletext serial stream with no bit clock, using a fixed
// 37-bit / 144-clock schedule. It gives a capture strobe, the captured bit and
// a line-wide bit number, and it stops after LINE_BITS bits.
// Assumes: line_start is a one-cycle pulse. bit_index and bit_data hold
// their last value between strobes.
module ttx_bit_sampler
    import ttx_pkg::*;
#(
    parameter int GROUP_BITS  = 37,
    parameter int FIRST_SHORT = 9,
    parameter int SHORT_EVERY = 9,
    parameter int LONG_CLKS   = 4,
    parameter int SHORT_CLKS  = 3,
    parameter int LINE_BITS   = 360
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         line_start,
    input  logic                         ser_data,
    output logic                         bit_valid,
    output logic                         bit_data,
    output logic [$clog2(LINE_BITS)-1:0] bit_index,
    output logic                         line_done,
    output logic                         cadence_err
);
    localparam int NUM_SHORT  = (GROUP_BITS - 1 - FIRST_SHORT) / SHORT_EVERY + 1;
    localparam int GROUP_CLKS = LONG_CLKS * GROUP_BITS
                              - (LONG_CLKS - SHORT_CLKS) * NUM_SHORT;
    localparam int IW = $clog2(LINE_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(LINE_BITS - 1);

    seq_state_t    state;
    logic          run;
    logic          is_short;
    logic          group_last;
    logic          sample_now;
    logic          bit_end;
    logic [IW-1:0] bit_ctr;

    assign run = (state == SEQ_RUN);

    ttx_cadence #(
        .GROUP_BITS (GROUP_BITS),
        .FIRST_SHORT(FIRST_SHORT),
        .SHORT_EVERY(SHORT_EVERY)
    ) u_cadence (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (line_start),
        .advance   (bit_end),
        .is_short  (is_short),
        .group_last(group_last)
    );

    ttx_bit_timer #(
        .LONG_CLKS (LONG_CLKS),
        .SHORT_CLKS(SHORT_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (line_start),
        .run       (run),
        .is_short  (is_short),
        .sample_now(sample_now),
        .bit_end   (bit_end)
    );

    ttx_group_monitor #(
        .GROUP_CLKS(GROUP_CLKS)
    ) u_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (line_start),
        .run      (run),
        .group_end(bit_end && group_last),
        .err      (cadence_err)
    );

    // Line control: arm on a line start, capture on the mid-bit clock, stop at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            bit_ctr   <= '0;
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
            bit_index <= '0;
            line_done <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            line_done <= 1'b0;
            if (line_start) begin
                state   <= SEQ_RUN;
                bit_ctr <= '0;
            end else if (sample_now) begin
                bit_valid <= 1'b1;
                bit_data  <= ser_data;
                bit_index <= bit_ctr;
                if (bit_ctr == LAST_IDX) begin
                    line_done <= 1'b1;
                    state     <= SEQ_IDLE;
                end else begin
                    bit_ctr <= bit_ctr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ttx_bit_sampler_chk.sv
// Module ttx_bit_sampler_chk
// Property checker for the bit sampler. It is attached to every instance of
// the top module by the bind statement below.
module ttx_bit_sampler_chk #(
    parameter int LINE_BITS = 360
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         line_start,
    input logic                         bit_valid,
    input logic [$clog2(LINE_BITS)-1:0] bit_index,
    input logic                         line_done,
    input logic                         cadence_err
);
    localparam int IW = $clog2(LINE_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(LINE_BITS - 1);

    AST_STROBE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);                                        // R9
    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (bit_valid && bit_index == LAST_IDX));              // R6
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (bit_index <= LAST_IDX));                           // R5
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (!bit_valid && !line_done));                       // R7
    AST_GROUP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !cadence_err);                                                    // R8
endmodule

bind ttx_bit_sampler ttx_bit_sampler_chk #(
    .LINE_BITS(LINE_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .bit_valid  (bit_valid),
    .bit_index  (bit_index),
    .line_done  (line_done),
    .cadence_err(cadence_err)
);

// File: tb/ttx_bit_sampler_test.sv
// Bench for ttx_bit_sampler. Random line data and random restart points are
// mixed with directed corner cases. The expected capture times come from the
// bit-length rule in the requirements.
module ttx_bit_sampler_test;
    localparam int NBITS = 360;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_start;
    logic       ser_data;
    logic       bit_valid;
    logic       bit_data;
    logic [8:0] bit_index;
    logic       line_done;
    logic       cadence_err;

    int total = 0;
    int bad   = 0;
    int bstart [NBITS];
    int strobe_at [NBITS];
    logic pattern [NBITS];

    always #4 clk = ~clk;

    ttx_bit_sampler uut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .ser_data(ser_data),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_index(bit_index),
        .line_done(line_done), .cadence_err(cadence_err)
    );

    // R2: positions 9, 18, 27, 36 of each 37-bit group last 3 clocks, the others 4.
    function automatic int bit_len(int n);
        int p = n % 37;
        return (p != 0 && p % 9 == 0) ? 3 : 4;
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Runs one line for `limit` clocks, starting from a negedge.
    task automatic run_line(int limit);
        int nxt = 0;
        int cur = 0;
        for (int n = 0; n < NBITS; n++) pattern[n] = 1'($urandom & 1);
        line_start = 1'b1;
        ser_data   = 1'($urandom & 1);
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 0; k < limit; k++) begin
            if (nxt < NBITS && strobe_at[nxt] == k) begin
                check_eq("R4", "bit_valid", int'(bit_valid), 1);
                check_eq("R4", "bit_data", int'(bit_data), int'(pattern[nxt]));
                check_eq("R5", "bit_index", int'(bit_index), nxt);
                check_eq("R6", "line_done", int'(line_done), (nxt == NBITS - 1) ? 1 : 0);
                nxt++;
            end else begin
                check_eq(k == 0 ? "R7" : "R3", "bit_valid idle", int'(bit_valid), 0);
                check_eq("R6", "line_done idle", int'(line_done), 0);
            end
            check_eq("R8", "cadence_err", int'(cadence_err), 0);
            while (cur < NBITS - 1 && k >= bstart[cur + 1]) cur++;
            if (k < bstart[NBITS - 1] + bit_len(NBITS - 1)) begin
                // The true value only in the capture clock, the inverse elsewhere (R4).
                ser_data = (k == bstart[cur] + bit_len(cur) / 2) ? pattern[cur] : ~pattern[cur];
            end else begin
                ser_data = 1'($urandom & 1);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int acc = 0;
        void'($urandom(32'd20240607));
        for (int n = 0; n < NBITS; n++) begin
            bstart[n]    = acc;
            strobe_at[n] = acc + bit_len(n) / 2 + 1;
            acc += bit_len(n);
        end
        // R2: the first group must total 144 clocks.
        check_eq("R2", "group clocks", bstart[37], 144);

        rst_n = 1'b0; line_start = 1'b0; ser_data = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1", "bit_valid in reset", int'(bit_valid), 0);
        check_eq("R1", "line_done in reset", int'(line_done), 0);
        check_eq("R1", "cadence_err in reset", int'(cadence_err), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            ser_data = 1'($urandom & 1);
            @(negedge clk);
            check_eq("R1", "no strobe before line start", int'(bit_valid), 0);
        end

        run_line(1410);                      // full line, then idle tail (R6)
        run_line(1410);                      // back-to-back line
        run_line(200 + int'($urandom % 1000)); // random mid-line restart (R7)
        run_line(1410);
        run_line(strobe_at[7] - 1);          // restart on a capture edge (R7)
        run_line(1410);
        run_line(strobe_at[40] + 2);         // restart after a group wrap
        run_line(1410);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule